// File: doc/BRIEF.md
# Mesh Router Route and Output-VC Allocator

This block performs connection setup for one router of a two-dimensional mesh. The router has five ports: Local, North, East, South and West. Each port has a number of virtual channels (VCs). When the first flit of a packet reaches an input VC, the block is told the packet's destination coordinates. A route computer for that input VC picks the output port with dimension-ordered XY routing. The request then joins a single arrival-ordered queue. A central ownership table serves the head of that queue: it reserves the lowest-numbered free VC on the chosen output port for the requesting input VC. The reservation holds until the packet's last flit has passed, and the flit datapath then reports that tail.

The block issues at most one grant per cycle. Each grant names the input VC, the output port and the output VC. The flit datapath, the credit logic and the crossbar use these grants; none of them is part of this block. An input VC is identified by the index `port*NVC + vc`.

Top module: `mesh_route_alloc`

## Requirements
- R1: After a synchronous active-low reset, `gnt_valid` is 0 and every output VC is free, so the first request to any port receives output VC 0.
- R2: Port codes are Local=0, North=1, East=2, South=3, West=4. East means destination X greater than `my_x`, and West means it is smaller. Only when the X values are equal is Y compared: North for a greater Y, South for a smaller Y. When both coordinates match, the packet goes to Local.
- R3: A header on an input VC is captured on one clock edge. When uncontended, `gnt_valid` is high for exactly one cycle after the following edge. The grant carries the requester's index, its routed port and its output VC.
- R4: The granted VC is the lowest-numbered VC of the routed port that was free in the cycle the grant was decided. That VC becomes owned by the requester.
- R5: At most one grant is issued per cycle. Headers arriving in the same cycle are granted in ascending input index, meaning port first and then VC.
- R6: Headers arriving in different cycles are granted in arrival order.
- R7: If the routed port of the oldest waiting request has no free VC, that request keeps its place at the head of the queue. No later request is granted before it, even one routed to a port with free VCs.
- R8: A tail notification on an input VC that holds a connection frees its output VC. A waiting request may take that VC in the next decision cycle.
- R9: A header on an input VC that is already waiting or connected is ignored and produces no second grant.
- R10: A tail notification on an input VC that holds no connection is ignored and frees nothing.
- R11: An output VC is never granted while it is owned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_x | input | CW | This router's X coordinate |
| my_y | input | CW | This router's Y coordinate |
| hdr_valid | input | 5*NVC | Per input VC: a header flit is present this cycle |
| hdr_dst_x | input | 5*NVC*CW | Per input VC: destination X field, slice `i*CW +: CW` |
| hdr_dst_y | input | 5*NVC*CW | Per input VC: destination Y field, slice `i*CW +: CW` |
| tail_done | input | 5*NVC | Per input VC: the packet's tail flit has left |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_src | output | clog2(5*NVC) | Index of the granted input VC |
| gnt_port | output | 3 | Output port code (see R2) |
| gnt_vc | output | clog2(NVC) | Output VC reserved on that port |

## Verification
The bench uses NVC=4 and CW=3, with the router placed at (3,4) in what can be an 8x8 mesh. Its destinations therefore lie on every side of the router, and so every port code is exercised. With four VCs per port, a single cycle of four headers fills one output port completely. This makes the blocked head of queue, the in-order release behind it and the reuse of a VC freed in the middle of the port's range all reachable in a few dozen cycles. Twenty input VCs give same-cycle bursts whose members are spread over different ports, so the ordering rule has to interleave port and VC indices.

// File: rtl/rva_pkg.sv
// Shared constants and types for the route / output-VC allocator.
// Assumes a five-port mesh router; port codes are fixed by the routing rule.
package rva_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;

    typedef enum logic [PW-1:0] {
        PORT_L = 3'd0,
        PORT_N = 3'd1,
        PORT_E = 3'd2,
        PORT_S = 3'd3,
        PORT_W = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        IVC_IDLE = 2'd0,
        IVC_WAIT = 2'd1,
        IVC_CONN = 2'd2
    } ivc_state_e;
endpackage

// File: rtl/xy_route_calc.sv
// Dimension-ordered route computer for one input VC.
// Purely combinational; assumes X grows toward East and Y toward North.
module xy_route_calc
    import rva_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output logic [PW-1:0] dir
);
    // X offset is resolved before Y; equal coordinates eject locally.
    always_comb begin
        if (dst_x > cur_x)       dir = PORT_E;
        else if (dst_x < cur_x)  dir = PORT_W;
        else if (dst_y > cur_y)  dir = PORT_N;
        else if (dst_y < cur_y)  dir = PORT_S;
        else                     dir = PORT_L;
    end
endmodule

// File: rtl/hdr_order_fifo.sv
// Arrival-ordered queue of input-VC indices.
// Accepts any subset of NIN requesters per cycle, storing them by ascending
// index, and pops one per cycle. Assumes each index is present at most once,
// so NIN entries can never overflow.
module hdr_order_fifo #(
    parameter int NIN = 20,
    parameter int IW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] push_vec,
    input  logic           pop,
    output logic           head_valid,
    output logic [IW-1:0]  head_idx
);
    localparam int CNTW = $clog2(NIN + 1);

    logic [IW-1:0]   mem [NIN];
    logic [IW-1:0]   slot [NIN];
    logic [IW-1:0]   rd_ptr, wr_ptr, wr_next, rd_next;
    logic [CNTW-1:0] count, npush;

    // Slot of every pushing requester: write pointer plus its rank.
    always_comb begin
        int unsigned rank;
        int unsigned pos;
        rank = 0;
        for (int i = 0; i < NIN; i++) begin
            pos = int'(wr_ptr) + rank;
            if (pos >= NIN) pos = pos - NIN;
            slot[i] = IW'(pos);
            if (push_vec[i]) rank = rank + 1;
        end
        npush = CNTW'(rank);
        pos = int'(wr_ptr) + rank;
        if (pos >= NIN) pos = pos - NIN;
        wr_next = IW'(pos);
        pos = int'(rd_ptr) + 1;
        if (pos >= NIN) pos = 0;
        rd_next = IW'(pos);
    end

    // Storage writes for every pushing requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NIN; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < NIN; i++)
                if (push_vec[i]) mem[slot[i]] <= IW'(i);
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_next;
            if (pop && head_valid) rd_ptr <= rd_next;
            count <= count + npush - CNTW'(pop && head_valid);
        end
    end

    assign head_valid = (count != '0);
    assign head_idx   = mem[rd_ptr];
endmodule

// File: rtl/ovc_table.sv
// Central ownership table for all output VCs of the router.
// Reports the lowest free VC of a selected port, records the owner on
// allocation and frees every VC owned by an input VC whose tail passed.
// Assumes sel_port is a valid port code whenever alloc_en is high.
module ovc_table
    import rva_pkg::*;
#(
    parameter int NVC = 4,
    parameter int NIN = 20,
    parameter int IW  = 5,
    parameter int VW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        sel_port,
    input  logic                 alloc_en,
    input  logic [IW-1:0]        alloc_src,
    input  logic [NIN-1:0]       release_vec,
    output logic                 has_free,
    output logic [VW-1:0]        free_vc,
    output logic [NPORT*NVC-1:0] busy_o
);
    localparam int NOUT = NPORT * NVC;

    logic [NOUT-1:0] busy;
    logic [IW-1:0]   owner [NOUT];

    // Lowest-numbered free VC on the selected output port.
    always_comb begin
        has_free = 1'b0;
        free_vc  = '0;
        if (int'(sel_port) < NPORT) begin
            for (int v = NVC - 1; v >= 0; v--) begin
                if (!busy[int'(sel_port) * NVC + v]) begin
                    has_free = 1'b1;
                    free_vc  = VW'(v);
                end
            end
        end
    end

    // Ownership updates: release on tail, claim on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int e = 0; e < NOUT; e++) owner[e] <= '0;
        end else begin
            for (int e = 0; e < NOUT; e++) begin
                if (busy[e] && int'(owner[e]) < NIN && release_vec[owner[e]])
                    busy[e] <= 1'b0;
                if (alloc_en && e == int'(sel_port) * NVC + int'(free_vc)) begin
                    busy[e]  <= 1'b1;
                    owner[e] <= alloc_src;
                end
            end
        end
    end

    assign busy_o = busy;
endmodule

// File: rtl/mesh_route_alloc.sv
// Route computation and output-VC allocation for one five-port mesh router.
// One XY route computer per input VC; requests are queued in arrival order
// and the queue head is served from the central table once its port has a
// free VC. Assumes the datapath raises tail_done once per packet.
module mesh_route_alloc
    import rva_pkg::*;
#(
    parameter int NVC = 4,
    parameter int CW  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CW-1:0]                 my_x,
    input  logic [CW-1:0]                 my_y,
    input  logic [NPORT*NVC-1:0]          hdr_valid,
    input  logic [NPORT*NVC*CW-1:0]       hdr_dst_x,
    input  logic [NPORT*NVC*CW-1:0]       hdr_dst_y,
    input  logic [NPORT*NVC-1:0]          tail_done,
    output logic                          gnt_valid,
    output logic [$clog2(NPORT*NVC)-1:0]  gnt_src,
    output logic [PW-1:0]                 gnt_port,
    output logic [$clog2(NVC)-1:0]        gnt_vc
);
    localparam int NIN = NPORT * NVC;
    localparam int IW  = $clog2(NIN);
    localparam int VW  = $clog2(NVC);

    ivc_state_e      st_q    [NIN];
    logic [PW-1:0]   route_q [NIN];
    logic [PW-1:0]   rc_dir  [NIN];
    logic [NIN-1:0]  push_vec, rel_vec;
    logic            head_valid, grant;
    logic [IW-1:0]   head_idx;
    logic [PW-1:0]   head_port;
    logic            tbl_has_free;
    logic [VW-1:0]   tbl_free_vc;
    logic [NIN-1:0]  ovc_busy;

    // One route computer per input VC, grouped by input port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar v = 0; v < NVC; v++) begin : g_vc
            localparam int IDX = p * NVC + v;
            xy_route_calc #(.CW(CW)) u_rc (
                .cur_x (my_x),
                .cur_y (my_y),
                .dst_x (hdr_dst_x[IDX*CW +: CW]),
                .dst_y (hdr_dst_y[IDX*CW +: CW]),
                .dir   (rc_dir[IDX])
            );
        end
    end

    // Only idle VCs accept headers; only connected VCs release.
    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            push_vec[i] = hdr_valid[i] && (st_q[i] == IVC_IDLE);
            rel_vec[i]  = tail_done[i] && (st_q[i] == IVC_CONN);
        end
    end

    hdr_order_fifo #(.NIN(NIN), .IW(IW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_vec   (push_vec),
        .pop        (grant),
        .head_valid (head_valid),
        .head_idx   (head_idx)
    );

    assign head_port = (int'(head_idx) < NIN) ? route_q[head_idx] : PORT_L;
    assign grant     = head_valid && tbl_has_free;

    ovc_table #(.NVC(NVC), .NIN(NIN), .IW(IW), .VW(VW)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_port    (head_port),
        .alloc_en    (grant),
        .alloc_src   (head_idx),
        .release_vec (rel_vec),
        .has_free    (tbl_has_free),
        .free_vc     (tbl_free_vc),
        .busy_o      (ovc_busy)
    );

    // Per-input-VC connection state and captured route.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NIN; i++) begin
                st_q[i]    <= IVC_IDLE;
                route_q[i] <= PORT_L;
            end
        end else begin
            for (int i = 0; i < NIN; i++) begin
                case (st_q[i])
                    IVC_IDLE: if (push_vec[i]) begin
                        st_q[i]    <= IVC_WAIT;
                        route_q[i] <= rc_dir[i];
                    end
                    IVC_WAIT: if (grant && int'(head_idx) == i) st_q[i] <= IVC_CONN;
                    IVC_CONN: if (rel_vec[i]) st_q[i] <= IVC_IDLE;
                    default:  st_q[i] <= IVC_IDLE;
                endcase
            end
        end
    end

    // Registered grant presented to the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_src   <= '0;
            gnt_port  <= '0;
            gnt_vc    <= '0;
        end else begin
            gnt_valid <= grant;
            gnt_src   <= head_idx;
            gnt_port  <= head_port;
            gnt_vc    <= tbl_free_vc;
        end
    end
endmodule

// File: rtl/rva_checker.sv
// Property checker for mesh_route_alloc, attached with bind.
// Watches the grant port against the central table's ownership vector.
module rva_checker
    import rva_pkg::*;
#(
    parameter int NVC = 4,
    parameter int NIN = 20,
    parameter int IW  = 5,
    parameter int VW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           gnt_valid,
    input logic [IW-1:0]  gnt_src,
    input logic [PW-1:0]  gnt_port,
    input logic [VW-1:0]  gnt_vc,
    input logic [NIN-1:0] tail_done,
    input logic [NIN-1:0] busy_flat
);
    logic [NIN-1:0] past_busy;
    logic now_busy, was_busy, lower_full;

    // Ownership vector delayed by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) past_busy <= '0;
        else        past_busy <= busy_flat;
    end

    // Status of the granted VC and its lower-numbered neighbours.
    always_comb begin
        now_busy   = 1'b0;
        was_busy   = 1'b1;
        lower_full = 1'b1;
        if (int'(gnt_port) < NPORT) begin
            now_busy = busy_flat[int'(gnt_port) * NVC + int'(gnt_vc)];
            was_busy = past_busy[int'(gnt_port) * NVC + int'(gnt_vc)];
            for (int v = 0; v < NVC; v++)
                if (v < int'(gnt_vc) && !past_busy[int'(gnt_port) * NVC + v])
                    lower_full = 1'b0;
        end
    end

    p_port_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (int'(gnt_port) < NPORT) && (int'(gnt_src) < NIN));

    p_no_double_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> now_busy && !was_busy);

    p_lowest_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> lower_full);

    p_no_regrant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !(gnt_valid && gnt_src == $past(gnt_src)));

    p_free_only_on_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_done == '0) |=> ($countones(busy_flat) >= $countones(past_busy)));
endmodule

bind mesh_route_alloc rva_checker #(
    .NVC (NVC),
    .NIN (NIN),
    .IW  (IW),
    .VW  (VW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_valid (gnt_valid),
    .gnt_src   (gnt_src),
    .gnt_port  (gnt_port),
    .gnt_vc    (gnt_vc),
    .tail_done (tail_done),
    .busy_flat (ovc_busy)
);

// File: tb/sim_mesh_route_alloc.sv
// Directed bench: one task per scenario, each checking its own grants.
module sim_mesh_route_alloc;
    localparam int NVC = 4;
    localparam int CW  = 3;
    localparam int NIN = 5 * NVC;
    localparam int IW  = $clog2(NIN);
    localparam int VW  = $clog2(NVC);
    localparam int P_L = 0, P_N = 1, P_E = 2, P_S = 3, P_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CW-1:0]      my_x = 3'd3;
    logic [CW-1:0]      my_y = 3'd4;
    logic [NIN-1:0]     hdr_valid = '0;
    logic [NIN*CW-1:0]  hdr_dst_x = '0;
    logic [NIN*CW-1:0]  hdr_dst_y = '0;
    logic [NIN-1:0]     tail_done = '0;
    logic               gnt_valid;
    logic [IW-1:0]      gnt_src;
    logic [2:0]         gnt_port;
    logic [VW-1:0]      gnt_vc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mesh_route_alloc #(.NVC(NVC), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
        .hdr_valid(hdr_valid), .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y),
        .tail_done(tail_done), .gnt_valid(gnt_valid), .gnt_src(gnt_src),
        .gnt_port(gnt_port), .gnt_vc(gnt_vc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put_hdr(input int s, input int dx, input int dy);
        hdr_dst_x[s*CW +: CW] = CW'(dx);
        hdr_dst_y[s*CW +: CW] = CW'(dy);
        hdr_valid[s] = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
        hdr_valid = '0;
        tail_done = '0;
    endtask

    task automatic release_vc(input int s);
        tail_done[s] = 1'b1;
        step();
    endtask

    // Wait up to 12 cycles for a grant, compare it, move past it.
    task automatic expect_grant(input int s, input int port, input int vc, input string req);
        bit seen = 0;
        for (int k = 0; k < 12 && !seen; k++) begin
            if (gnt_valid) seen = 1;
            else @(negedge clk);
        end
        check(seen, req, "grant seen", int'(seen), 1);
        if (seen) begin
            check(int'(gnt_src) == s, req, "grant source", int'(gnt_src), s);
            check(int'(gnt_port) == port, req, "grant port", int'(gnt_port), port);
            check(int'(gnt_vc) == vc, req, "grant vc", int'(gnt_vc), vc);
            @(negedge clk);
        end
    endtask

    task automatic expect_none(input int cycles, input string req);
        bit any = 0;
        for (int k = 0; k < cycles; k++) begin
            if (gnt_valid) any = 1;
            @(negedge clk);
        end
        check(!any, req, "no grant in window", int'(any), 0);
    endtask

    task automatic t_reset();
        check(gnt_valid == 1'b0, "R1", "gnt_valid after reset", int'(gnt_valid), 0);
    endtask

    // R2/R3: each direction, exact grant cycle, VC 0 available each time.
    task automatic t_xy_one(input int s, input int dx, input int dy, input int port);
        put_hdr(s, dx, dy);
        step();
        check(gnt_valid == 1'b0, "R3", "no grant one edge after header", int'(gnt_valid), 0);
        @(negedge clk);
        check(gnt_valid == 1'b1, "R3", "grant two edges after header", int'(gnt_valid), 1);
        check(int'(gnt_port) == port, "R2", "xy port", int'(gnt_port), port);
        check(int'(gnt_src) == s, "R3", "grant source", int'(gnt_src), s);
        check(gnt_vc == '0, "R1", "first vc free", int'(gnt_vc), 0);
        @(negedge clk);
        check(gnt_valid == 1'b0, "R3", "grant lasts one cycle", int'(gnt_valid), 0);
        release_vc(s);
    endtask

    task automatic t_xy();
        t_xy_one(0, 5, 1, P_E);
        t_xy_one(5, 1, 7, P_W);
        t_xy_one(9, 3, 7, P_N);
        t_xy_one(14, 3, 0, P_S);
        t_xy_one(19, 3, 4, P_L);
    endtask

    // R5/R4: same-cycle burst to one port, ordered by index.
    task automatic t_same_cycle();
        put_hdr(13, 6, 2);
        put_hdr(2, 7, 4);
        put_hdr(7, 4, 0);
        step();
        expect_grant(2, P_E, 0, "R5");
        expect_grant(7, P_E, 1, "R5");
        expect_grant(13, P_E, 2, "R4");
        tail_done[2] = 1'b1; tail_done[7] = 1'b1; tail_done[13] = 1'b1;
        step();
    endtask

    // R6: later-cycle lower index waits for earlier higher index.
    task automatic t_order_cycles();
        put_hdr(18, 3, 6);
        step();
        put_hdr(1, 3, 5);
        step();
        expect_grant(18, P_N, 0, "R6");
        expect_grant(1, P_N, 1, "R6");
        tail_done[18] = 1'b1; tail_done[1] = 1'b1;
        step();
    endtask

    // R7/R8: full port blocks the head and everything behind it.
    task automatic t_full_block();
        for (int s = 0; s < 4; s++) put_hdr(s, 7, 4);
        step();
        for (int s = 0; s < 4; s++) expect_grant(s, P_E, s, "R4");
        put_hdr(4, 6, 4);
        step();
        put_hdr(5, 0, 4);
        step();
        expect_none(5, "R7");
        release_vc(2);
        expect_grant(4, P_E, 2, "R8");
        expect_grant(5, P_W, 0, "R7");
        for (int s = 0; s < 6; s++) tail_done[s] = 1'b1;
        step();
    endtask

    // R9: a second header on a connected input VC is dropped.
    task automatic t_ignore_hdr();
        put_hdr(6, 0, 0);
        step();
        expect_grant(6, P_W, 0, "R9");
        put_hdr(6, 0, 0);
        step();
        expect_none(4, "R9");
        release_vc(6);
        put_hdr(6, 0, 0);
        step();
        expect_grant(6, P_W, 0, "R8");
        release_vc(6);
    endtask

    // R10: tail on an idle input VC frees nothing.
    task automatic t_ignore_tail();
        for (int s = 8; s < 12; s++) put_hdr(s, 2, 7);
        step();
        for (int s = 8; s < 12; s++) expect_grant(s, P_W, s - 8, "R4");
        release_vc(12);
        put_hdr(13, 0, 2);
        step();
        expect_none(4, "R10");
        release_vc(9);
        expect_grant(13, P_W, 1, "R10");
        for (int s = 8; s < 14; s++) tail_done[s] = 1'b1;
        step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_xy();
        t_same_cycle();
        t_order_cycles();
        t_full_block();
        t_ignore_hdr();
        t_ignore_tail();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule